// File: doc/BRIEF.md
# Capture FIFO with Threshold-Driven DMA Request

This block sits between an image capture front end and system memory. It stores 32-bit words in a 128-entry first-in first-out buffer. It asks a DMA engine for service once the fill level reaches a programmable threshold. It also keeps sticky event flags, which a per-bit enable mask folds into one interrupt line. Software can observe the read pointer, the write pointer, the current fill level and the highest fill level seen.

The writer and the reader use single-cycle strobes. A read returns its word on `rdData` one clock after the strobe. A flag is set by hardware and cleared by a strobe bit of 1 on `flagClr`. A synchronous `clear` input resets the storage side without touching the flags.

Top module: `capt_fifo`

## Requirements
- R1: Words come out in the order they were written. `rdData` is registered: it carries the word chosen by a read strobe from the clock edge that samples the strobe until the next read.
- R2: `level` counts stored words from 0 to 128. `wrPtr` and `rdPtr` advance by one per accepted write or read and wrap from 127 to 0, so that `wrPtr - rdPtr` modulo 128 equals `level` modulo 128.
- R3: A write strobe while `level` is 128 is dropped: the stored contents and `level` stay unchanged. The same edge sets the overflow flag, `flags[1]`.
- R4: A read strobe while `level` is 0 loads 0 into `rdData` and leaves `level` at 0. The same edge sets the underflow flag, `flags[0]`.
- R5: `peak` holds the largest `level` reached since reset or the last `clear`, and it follows `level` in the same cycle.
- R6: `thrSel` is 7 bits wide; a value of n means a threshold of n+1. With `dmaEn` at 1, `dmaReq` is 1 exactly while `level` >= `thrSel`+1. A value of 0 requests at 1 word; a value of 127 requests only at 128 words.
- R7: While `dmaEn` is 0, `dmaReq` is 0.
- R8: Three level flags are set at the clock edge after their condition holds on `level`: not-empty `flags[4]` (level > 0), full `flags[3]` (level = 128) and threshold `flags[2]` (level >= `thrSel`+1).
- R9: Each capture event input sets its flag at the edge where it is sampled high: frame end `flags[5]`, line start `flags[6]`, line end `flags[7]` and frame start `flags[8]`.
- R10: A `flagClr` bit of 1 clears the matching flag at the next edge, and a bit of 0 leaves it unchanged. If a flag is set and cleared at the same edge, the set wins.
- R11: `irq` is 1 exactly when some flag is 1 and its bit in `irqEnable` is 1.
- R12: A `clear` strobe empties the buffer. After the edge, both pointers, `level`, `peak` and `rdData` are 0, whatever write or read strobe came in the same cycle. The flags are not changed by it.
- R13: After reset, pointers, `level`, `peak`, `rdData`, `flags`, `dmaReq` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous buffer flush strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Word to store |
| rdEn | input | 1 | Read strobe |
| rdData | output | 32 | Word returned by the last read |
| dmaEn | input | 1 | Enables the DMA request |
| thrSel | input | 7 | Threshold minus one |
| dmaReq | output | 1 | DMA service request |
| frameStart | input | 1 | Frame start event pulse |
| frameEnd | input | 1 | Frame end event pulse |
| lineStart | input | 1 | Line start event pulse |
| lineEnd | input | 1 | Line end event pulse |
| flagClr | input | 9 | Write-one-to-clear strobes for the flags |
| irqEnable | input | 9 | Per-flag interrupt enable |
| flags | output | 9 | Sticky event flags |
| irq | output | 1 | Combined interrupt |
| rdPtr | output | 7 | Read pointer |
| wrPtr | output | 7 | Write pointer |
| level | output | 8 | Current fill level |
| peak | output | 8 | Highest fill level |

## Verification
The bench fills the buffer to exactly 128 words and then writes once more. A design that counted the level in seven bits, or that let the extra write through, would show a level of 0 or a corrupted last word when the buffer is drained. A read from an empty buffer must return zero rather than a stale word, and the threshold is checked at both ends of its encoding, where an off-by-one error would move the request by one word. The bench also clears a level flag while its condition still holds, clears other flags with zero bits, and raises `clear` together with a write. A wrong priority in any of these would leave a flag dropped, a flag cleared, or a word in the buffer.

// File: rtl/capt_fifo_pkg.sv
package capt_fifo_pkg;
  localparam int FLAG_N    = 9;
  localparam int FL_UNDER  = 0;
  localparam int FL_OVER   = 1;
  localparam int FL_THR    = 2;
  localparam int FL_FULL   = 3;
  localparam int FL_NEMPTY = 4;
  localparam int FL_EVT0   = 5;  // first of the capture event flags
  localparam int EVT_N     = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic push;   // accepted write
    logic pop;    // accepted read
    logic drain;  // read of an empty buffer
    logic flush;  // synchronous clear
  } fifoCmd_t;
endpackage

// File: rtl/capt_fifo_dp.sv
module capt_fifo_dp
  import capt_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoCmd_t          cmd,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] rdPtr,
  output logic [ADDR_W-1:0] wrPtr,
  output logic [ADDR_W:0]   level,
  output logic [ADDR_W:0]   peak
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LVL_W = ADDR_W + 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [LVL_W-1:0]  levelNext;

  always_comb begin
    if (cmd.flush) levelNext = '0;
    else levelNext = level + LVL_W'(cmd.push) - LVL_W'(cmd.pop);
  end

  always_ff @(posedge clk) begin
    if (cmd.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr  <= '0;
      wrPtr  <= '0;
      level  <= '0;
      peak   <= '0;
      rdData <= '0;
    end else if (cmd.flush) begin
      rdPtr  <= '0;
      wrPtr  <= '0;
      level  <= '0;
      peak   <= '0;
      rdData <= '0;
    end else begin
      if (cmd.push) wrPtr <= wrPtr + ADDR_W'(1);
      if (cmd.pop) begin
        rdPtr  <= rdPtr + ADDR_W'(1);
        rdData <= mem[rdPtr];
      end else if (cmd.drain) begin
        rdData <= '0;
      end
      level <= levelNext;
      if (levelNext > peak) peak <= levelNext;
    end
  end
endmodule

// File: rtl/capt_fifo_ctrl.sv
module capt_fifo_ctrl
  import capt_fifo_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W:0]   level,
  input  logic              dmaEn,
  input  logic [ADDR_W-1:0] thrSel,
  input  logic [EVT_N-1:0]  events,
  input  logic [FLAG_N-1:0] flagClr,
  input  logic [FLAG_N-1:0] irqEnable,
  output fifoCmd_t          cmd,
  output logic [FLAG_N-1:0] flags,
  output logic              dmaReq,
  output logic              irq
);
  localparam int LVL_W = ADDR_W + 1;
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(1 << ADDR_W);

  logic              isFull;
  logic              isEmpty;
  logic              thrHit;
  logic [LVL_W-1:0]  thrLimit;
  logic [FLAG_N-1:0] setVec;

  assign isFull   = (level == FULL_LVL);
  assign isEmpty  = (level == '0);
  assign thrLimit = LVL_W'(thrSel) + LVL_W'(1);
  assign thrHit   = (level >= thrLimit);

  assign cmd.flush = clear;
  assign cmd.push  = wrEn && !isFull && !clear;
  assign cmd.pop   = rdEn && !isEmpty && !clear;
  assign cmd.drain = rdEn && isEmpty && !clear;

  assign setVec[FL_UNDER]  = cmd.drain;
  assign setVec[FL_OVER]   = wrEn && isFull && !clear;
  assign setVec[FL_THR]    = thrHit;
  assign setVec[FL_FULL]   = isFull;
  assign setVec[FL_NEMPTY] = !isEmpty;

  for (genvar e = 0; e < EVT_N; e++) begin : g_evt
    assign setVec[FL_EVT0 + e] = events[e];
  end

  for (genvar f = 0; f < FLAG_N; f++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flags[f] <= 1'b0;
      else if (setVec[f]) flags[f] <= 1'b1;
      else if (flagClr[f]) flags[f] <= 1'b0;
    end
  end

  assign dmaReq = dmaEn && thrHit;
  assign irq    = |(flags & irqEnable);
endmodule

// File: rtl/capt_fifo.sv
module capt_fifo
  import capt_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  input  logic              dmaEn,
  input  logic [ADDR_W-1:0] thrSel,
  output logic              dmaReq,
  input  logic              frameStart,
  input  logic              frameEnd,
  input  logic              lineStart,
  input  logic              lineEnd,
  input  logic [FLAG_N-1:0] flagClr,
  input  logic [FLAG_N-1:0] irqEnable,
  output logic [FLAG_N-1:0] flags,
  output logic              irq,
  output logic [ADDR_W-1:0] rdPtr,
  output logic [ADDR_W-1:0] wrPtr,
  output logic [ADDR_W:0]   level,
  output logic [ADDR_W:0]   peak
);
  fifoCmd_t         cmd;
  logic [EVT_N-1:0] events;

  assign events = {frameStart, lineEnd, lineStart, frameEnd};

  capt_fifo_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .clear(clear), .wrEn(wrEn), .rdEn(rdEn),
    .level(level), .dmaEn(dmaEn), .thrSel(thrSel), .events(events),
    .flagClr(flagClr), .irqEnable(irqEnable), .cmd(cmd), .flags(flags),
    .dmaReq(dmaReq), .irq(irq)
  );

  capt_fifo_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrData(wrData), .rdData(rdData),
    .rdPtr(rdPtr), .wrPtr(wrPtr), .level(level), .peak(peak)
  );
endmodule

// File: rtl/capt_fifo_chk.sv
module capt_fifo_chk
  import capt_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              clear,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic              rdEn,
  input logic [DATA_W-1:0] rdData,
  input logic              dmaEn,
  input logic [ADDR_W-1:0] thrSel,
  input logic              dmaReq,
  input logic              frameStart,
  input logic              frameEnd,
  input logic              lineStart,
  input logic              lineEnd,
  input logic [FLAG_N-1:0] flagClr,
  input logic [FLAG_N-1:0] irqEnable,
  input logic [FLAG_N-1:0] flags,
  input logic              irq,
  input logic [ADDR_W-1:0] rdPtr,
  input logic [ADDR_W-1:0] wrPtr,
  input logic [ADDR_W:0]   level,
  input logic [ADDR_W:0]   peak
);
  localparam logic [ADDR_W:0] FULL_LVL = (ADDR_W+1)'(1 << ADDR_W);

  p_dma_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    !dmaEn |-> !dmaReq);

  p_level_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    level <= FULL_LVL);

  p_ptr_level_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdPtr + level[ADDR_W-1:0]) == wrPtr);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (level == FULL_LVL && wrEn && !rdEn && !clear) |=>
      (level == FULL_LVL && flags[FL_OVER]));

  p_underflow_r4: assert property (@(posedge clk) disable iff (!rstN)
    (level == '0 && rdEn && !clear) |=> (rdData == '0 && flags[FL_UNDER]));

  p_peak_r5: assert property (@(posedge clk) disable iff (!rstN)
    peak >= level);

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (flags[FL_UNDER] && !flagClr[FL_UNDER]) |=> flags[FL_UNDER]);

  p_irq_mask_r11: assert property (@(posedge clk) disable iff (!rstN)
    (irqEnable == '0) |-> !irq);

  p_clear_r12: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (level == '0 && peak == '0 && rdPtr == '0 && wrPtr == '0));
endmodule

bind capt_fifo capt_fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/capt_fifo_bench.sv
`timescale 1ns/1ps
module capt_fifo_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clear = 1'b0, wrEn = 1'b0, rdEn = 1'b0, dmaEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [6:0]  thrSel = '0;
  logic        frameStart = 1'b0, frameEnd = 1'b0, lineStart = 1'b0, lineEnd = 1'b0;
  logic [8:0]  flagClr = '0, irqEnable = '0;
  logic [31:0] rdData;
  logic        dmaReq, irq;
  logic [8:0]  flags;
  logic [6:0]  rdPtr, wrPtr;
  logic [7:0]  level, peak;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  capt_fifo u_capt_fifo (.*);

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int i);
    return 32'hA500_0000 | 32'(i * 3 + 1);
  endfunction

  task automatic push(input logic [31:0] d);
    wrEn = 1'b1; wrData = d; tick(); wrEn = 1'b0;
  endtask

  task automatic pop();
    rdEn = 1'b1; tick(); rdEn = 1'b0;
  endtask

  task automatic doClear();
    clear = 1'b1; tick(); clear = 1'b0;
  endtask

  task automatic clrFlags();
    flagClr = '1; tick(); flagClr = '0;
  endtask

  task automatic t_reset();
    chk("R13 level", 32'(level), 0);
    chk("R13 peak", 32'(peak), 0);
    chk("R13 ptrs", {rdPtr, wrPtr}, 0);
    chk("R13 flags", 32'(flags), 0);
    chk("R13 rdData", rdData, 0);
    chk("R13 dmaReq/irq", {dmaReq, irq}, 0);
  endtask

  task automatic t_order();
    for (int i = 0; i < 5; i++) push(pat(i));
    chk("R2 level after 5", 32'(level), 5);
    chk("R2 wrPtr", 32'(wrPtr), 5);
    for (int i = 0; i < 5; i++) begin
      pop();
      chk("R1 order", rdData, pat(i));
    end
    chk("R2 rdPtr", 32'(rdPtr), 5);
    chk("R5 peak", 32'(peak), 5);
    doClear();
  endtask

  task automatic t_fill();
    dmaEn = 1'b1; thrSel = 7'd127;
    for (int i = 0; i < 127; i++) push(pat(i));
    chk("R6 no request at 127 with thr 128", 32'(dmaReq), 0);
    push(pat(127));
    chk("R2 level 128", 32'(level), 128);
    chk("R2 wrPtr wraps", 32'(wrPtr), 0);
    chk("R6 request at 128", 32'(dmaReq), 1);
    tick();
    chk("R8 full and threshold flags", 32'(flags[4:2]), 3'b111);
    push(32'hDEAD_BEEF);
    chk("R3 level held", 32'(level), 128);
    chk("R3 overflow flag", 32'(flags[1]), 1);
    for (int i = 0; i < 128; i++) begin
      pop();
      if (rdData !== pat(i)) chk("R3 drained word", rdData, pat(i));
    end
    checks++;
    chk("R3 last word not overwritten", rdData, pat(127));
    chk("R2 rdPtr wraps", 32'(rdPtr), 0);
    chk("R5 peak 128", 32'(peak), 128);
    dmaEn = 1'b0;
  endtask

  task automatic t_underflow();
    doClear(); clrFlags();
    chk("R10 flags cleared", 32'(flags), 0);
    pop();
    chk("R4 zero data", rdData, 0);
    chk("R4 level", 32'(level), 0);
    chk("R4 underflow flag", 32'(flags[0]), 1);
    flagClr = 9'h1FE; tick(); flagClr = '0;
    chk("R10 zero bit leaves flag", 32'(flags[0]), 1);
    flagClr = 9'h001; tick(); flagClr = '0;
    chk("R10 one bit clears flag", 32'(flags[0]), 0);
  endtask

  task automatic t_threshold();
    doClear(); clrFlags();
    dmaEn = 1'b1; thrSel = 7'd3;
    for (int i = 0; i < 3; i++) push(pat(i));
    chk("R6 below threshold 4", 32'(dmaReq), 0);
    push(pat(3));
    chk("R6 at threshold 4", 32'(dmaReq), 1);
    dmaEn = 1'b0; #1;
    chk("R7 disabled", 32'(dmaReq), 0);
    dmaEn = 1'b1;
    doClear();
    thrSel = 7'd0; #1;
    chk("R6 thr 1 empty", 32'(dmaReq), 0);
    push(pat(9));
    chk("R6 thr 1 one word", 32'(dmaReq), 1);
    tick();
    chk("R8 not-empty flag", 32'(flags[4]), 1);
    flagClr = 9'h010; tick(); flagClr = '0;
    chk("R10 set wins over clear", 32'(flags[4]), 1);
    dmaEn = 1'b0;
    doClear();
  endtask

  task automatic t_events();
    clrFlags();
    chk("R9 flags idle", 32'(flags), 0);
    lineEnd = 1'b1; tick(); lineEnd = 1'b0;
    chk("R9 line end flag", 32'(flags), 9'h080);
    frameStart = 1'b1; frameEnd = 1'b1; lineStart = 1'b1; tick();
    frameStart = 1'b0; frameEnd = 1'b0; lineStart = 1'b0;
    chk("R9 all event flags", 32'(flags), 9'h1E0);
    chk("R11 masked", 32'(irq), 0);
    irqEnable = 9'h01F; #1;
    chk("R11 other bits enabled", 32'(irq), 0);
    irqEnable = 9'h080; #1;
    chk("R11 enabled event", 32'(irq), 1);
    flagClr = 9'h080; tick(); flagClr = '0;
    chk("R11 cleared drops irq", 32'(irq), 0);
    irqEnable = '0;
  endtask

  task automatic t_clear();
    for (int i = 0; i < 6; i++) push(pat(i));
    pop();
    tick();
    chk("R12 prep flag", 32'(flags[4]), 1);
    clear = 1'b1; wrEn = 1'b1; wrData = 32'h1234_5678; tick();
    clear = 1'b0; wrEn = 1'b0;
    chk("R12 level", 32'(level), 0);
    chk("R12 ptrs", {rdPtr, wrPtr}, 0);
    chk("R12 peak", 32'(peak), 0);
    chk("R12 rdData", rdData, 0);
    chk("R12 flags kept", 32'(flags[4]), 1);
    push(pat(40));
    pop();
    chk("R12 fresh word after clear", rdData, pat(40));
  endtask

  initial begin
    tick(); tick();
    rstN = 1'b1;
    tick();
    t_reset();
    t_order();
    t_fill();
    t_underflow();
    t_threshold();
    t_events();
    t_clear();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule